// File: doc/BRIEF.md
# Three-Wire Latched Control Register Port

This block receives configuration words for a stereo playback path over three external wires: a control clock, a control data line and a latch strobe. All three wires are treated as asynchronous. Each passes through a two-flop synchronizer into the system clock domain, and the block detects edges there. On every rising edge of the control clock, one data bit enters a shift register, most significant bit first. When the latch strobe rises, the most recent 16 bits are committed to the register selected by the two top bits of the word.

The control clock may run all the time or only while a word is sent. For this reason the block never infers word boundaries from gaps in the clock. The latch alone frames a word. Whatever sits in the last sixteen bit positions at that moment is the word, and older bits are dropped. A latch that arrives before sixteen bits have been shifted since the previous latch (or since reset) commits nothing. Words to the unused address are discarded.

The configuration outputs are plain level signals: serial data format, input word length, sample-rate mode, de-emphasis selection, mute, output phase inversion, and separate left and right volume. There is no streaming data path and so no back-pressure. A host can send words at any rate the oversampling allows.

Top module: `serctl_port`

## Requirements
- R1: While rst_n is low, every output takes its default value: fmt_o=0, wlen_o=0, rate_o=0, deemph_o=0, mute_o=0, invert_o=0, vol_l_o and vol_r_o all ones. Reset also discards any partly shifted word.
- R2: A data bit is taken at the rising edge of ctl_clk_i, MSB first. A change of ctl_dat_i while ctl_clk_i is high, or at its falling edge, does not alter the captured bit.
- R3: Shifting bits changes no output. Outputs change only after a rising edge of ctl_lat_i.
- R4: When more than 16 bits are shifted before a latch, only the last 16 are used.
- R5: A latch rising edge that comes after fewer than 16 control clock rising edges since the previous latch or reset is ignored, and all outputs keep their values.
- R6: Word bits 15:14 hold the address. Address 0 writes the format register from payload bits: fmt_o=[1:0], wlen_o=[3:2], rate_o=[5:4], deemph_o=[7:6], mute_o=[8], invert_o=[9].
- R7: Address 1 writes vol_l_o and address 2 writes vol_r_o from payload bits [9:0]. Each write leaves the other registers untouched.
- R8: A word with address 3 changes no output.
- R9: Payload bits 13:10 are ignored for all addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the control wires |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| ctl_clk_i | input | 1 | Control clock, continuous or gated |
| ctl_dat_i | input | 1 | Control data, MSB first |
| ctl_lat_i | input | 1 | Latch strobe; rising edge commits the word |
| fmt_o | output | 2 | Serial data format select |
| wlen_o | output | 2 | Input word length select |
| rate_o | output | 2 | Sample-rate mode |
| deemph_o | output | 2 | De-emphasis select |
| mute_o | output | 1 | Soft mute request |
| invert_o | output | 1 | Output phase inversion |
| vol_l_o | output | 10 | Left channel volume |
| vol_r_o | output | 10 | Right channel volume |

## Verification
Words are sent with clean setup and with data that flips while the control clock is high. This separates rising-edge capture from sampling at any other time. Words that are exactly 16 bits long are compared with words that carry leading junk bits and with short bursts. These show that the latch, and not any bit count, frames the word, and that incomplete words are dropped. Each address is written with a distinct pattern, and the other registers are checked after every write, so a decode error or a stray write shows up. Address 3 and the upper payload bits are filled with ones to show that they have no effect.

// File: rtl/serctl_pkg.sv
`timescale 1ns/1ps
package serctl_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_FMT  = 2'd0,
    ADR_VOLL = 2'd1,
    ADR_VOLR = 2'd2,
    ADR_RSVD = 2'd3
  } reg_adr_e;

  // Payload layout of the format register, LSB at fmt.
  typedef struct packed {
    logic       invert;
    logic       mute;
    logic [1:0] deemph;
    logic [1:0] rate;
    logic [1:0] wlen;
    logic [1:0] fmt;
  } fmt_cfg_t;

  localparam int FMT_W = $bits(fmt_cfg_t);
  localparam fmt_cfg_t FMT_DEFAULT = '0;
endpackage

// File: rtl/serctl_sync.sv
`timescale 1ns/1ps
// Per-signal synchronizer chain plus rising-edge detector.
module serctl_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o
);
  for (genvar b = 0; b < N; b++) begin : g_sig
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], async_i[b]};
        prev  <= chain[STAGES-1];
      end
    end
    assign lvl_o[b]  = chain[STAGES-1];
    assign rise_o[b] = chain[STAGES-1] & ~prev;
  end
endmodule

// File: rtl/serctl_shift.sv
`timescale 1ns/1ps
// Shift register framed by the latch; commits only complete words.
module serctl_shift #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic              lat_stb_i,
  output logic [WORD_W-1:0] word_o,
  output logic              commit_o
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [WORD_W-1:0] sh;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      cnt      <= '0;
      word_o   <= '0;
      commit_o <= 1'b0;
    end else if (lat_stb_i) begin
      commit_o <= (cnt == FULL);
      word_o   <= sh;
      cnt      <= '0;
    end else begin
      commit_o <= 1'b0;
      if (bit_stb_i) begin
        sh <= {sh[WORD_W-2:0], bit_val_i};
        if (cnt != FULL) cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serctl_regs.sv
`timescale 1ns/1ps
// Address decode and configuration storage.
module serctl_regs
  import serctl_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int VOL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output fmt_cfg_t          cfg_o,
  output logic [VOL_W-1:0]  vol_l_o,
  output logic [VOL_W-1:0]  vol_r_o
);
  localparam int PAY_W = WORD_W - ADDR_W;

  reg_adr_e         adr;
  logic [PAY_W-1:0] pay;
  logic             unused_hi;

  assign adr       = reg_adr_e'(word_i[WORD_W-1 -: ADDR_W]);
  assign pay       = word_i[PAY_W-1:0];
  assign unused_hi = ^pay[PAY_W-1:FMT_W] ^ ^pay[PAY_W-1:VOL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_o   <= FMT_DEFAULT;
      vol_l_o <= '1;
      vol_r_o <= '1;
    end else if (commit_i) begin
      unique case (adr)
        ADR_FMT:  cfg_o   <= fmt_cfg_t'(pay[FMT_W-1:0]);
        ADR_VOLL: vol_l_o <= pay[VOL_W-1:0];
        ADR_VOLR: vol_r_o <= pay[VOL_W-1:0];
        ADR_RSVD: ;
      endcase
    end
  end
endmodule

// File: rtl/serctl_port.sv
`timescale 1ns/1ps
module serctl_port
  import serctl_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int VOL_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_clk_i,
  input  logic             ctl_dat_i,
  input  logic             ctl_lat_i,
  output logic [1:0]       fmt_o,
  output logic [1:0]       wlen_o,
  output logic [1:0]       rate_o,
  output logic [1:0]       deemph_o,
  output logic             mute_o,
  output logic             invert_o,
  output logic [VOL_W-1:0] vol_l_o,
  output logic [VOL_W-1:0] vol_r_o
);
  localparam int IDX_CLK = 0;
  localparam int IDX_DAT = 1;
  localparam int IDX_LAT = 2;

  logic [2:0]        s_lvl, s_rise;
  logic [WORD_W-1:0] cmd_word;
  logic              commit;
  fmt_cfg_t          cfg;
  logic              unused_sync;

  serctl_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i({ctl_lat_i, ctl_dat_i, ctl_clk_i}),
    .lvl_o  (s_lvl),
    .rise_o (s_rise)
  );

  assign unused_sync = s_lvl[IDX_CLK] ^ s_lvl[IDX_LAT] ^ s_rise[IDX_DAT];

  serctl_shift #(.WORD_W(WORD_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_stb_i(s_rise[IDX_CLK]),
    .bit_val_i(s_lvl[IDX_DAT]),
    .lat_stb_i(s_rise[IDX_LAT]),
    .word_o   (cmd_word),
    .commit_o (commit)
  );

  serctl_regs #(.WORD_W(WORD_W), .VOL_W(VOL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit_i(commit),
    .word_i  (cmd_word),
    .cfg_o   (cfg),
    .vol_l_o (vol_l_o),
    .vol_r_o (vol_r_o)
  );

  assign fmt_o    = cfg.fmt;
  assign wlen_o   = cfg.wlen;
  assign rate_o   = cfg.rate;
  assign deemph_o = cfg.deemph;
  assign mute_o   = cfg.mute;
  assign invert_o = cfg.invert;
endmodule

// File: rtl/serctl_port_chk.sv
`timescale 1ns/1ps
module serctl_port_chk #(
  parameter int WORD_W = 16,
  parameter int VOL_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic [WORD_W-1:0] cmd_word,
  input logic [9:0]        fmt_bits,
  input logic [VOL_W-1:0]  vol_l,
  input logic [VOL_W-1:0]  vol_r
);
  logic [1:0] adr;
  assign adr = cmd_word[WORD_W-1 -: 2];

  // R1: one edge with reset low yields defaults
  a_r1_reset_defaults: assert property (@(posedge clk)
    !rst_n |=> (fmt_bits == '0 && vol_l == '1 && vol_r == '1));

  // R3: no commit, no change
  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(fmt_bits) && $stable(vol_l) && $stable(vol_r)));

  // R5: commits come from separate latch edges
  a_r5_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);

  // R7: left volume written only by address 1
  a_r7_left_vol_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && adr != 2'd1) |=> $stable(vol_l));

  // R8: reserved address leaves all outputs unchanged
  a_r8_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && adr == 2'd3) |=> ($stable(fmt_bits) && $stable(vol_l) && $stable(vol_r)));
endmodule

bind serctl_port serctl_port_chk #(.WORD_W(WORD_W), .VOL_W(VOL_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .commit  (commit),
  .cmd_word(cmd_word),
  .fmt_bits({invert_o, mute_o, deemph_o, rate_o, wlen_o, fmt_o}),
  .vol_l   (vol_l_o),
  .vol_r   (vol_r_o)
);

// File: tb/test_serctl_port.sv
`timescale 1ns/1ps
module test_serctl_port;
  localparam int VOL_W = 10;

  logic clk = 1'b0;
  logic rst_n, ctl_clk, ctl_dat, ctl_lat;
  logic [1:0] fmt, wlen, rate, deemph;
  logic mute, invert;
  logic [VOL_W-1:0] vol_l, vol_r;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [9:0] e_fmt;
  logic [VOL_W-1:0] e_vl, e_vr;

  always #10 clk = ~clk;

  serctl_port i_serctl_port (
    .clk(clk), .rst_n(rst_n), .ctl_clk_i(ctl_clk), .ctl_dat_i(ctl_dat),
    .ctl_lat_i(ctl_lat), .fmt_o(fmt), .wlen_o(wlen), .rate_o(rate),
    .deemph_o(deemph), .mute_o(mute), .invert_o(invert),
    .vol_l_o(vol_l), .vol_r_o(vol_r)
  );

  task automatic sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, "fmt",    fmt,    e_fmt[1:0]);
    chk(req, "wlen",   wlen,   e_fmt[3:2]);
    chk(req, "rate",   rate,   e_fmt[5:4]);
    chk(req, "deemph", deemph, e_fmt[7:6]);
    chk(req, "mute",   mute,   e_fmt[8]);
    chk(req, "invert", invert, e_fmt[9]);
    chk(req, "vol_l",  vol_l,  e_vl);
    chk(req, "vol_r",  vol_r,  e_vr);
  endtask

  task automatic put_bits(input logic [31:0] v, input int n, input bit flip);
    for (int i = n - 1; i >= 0; i--) begin
      ctl_dat = v[i];
      sys(4);
      ctl_clk = 1'b1;
      sys(2);
      if (flip) ctl_dat = ~v[i];
      sys(2);
      ctl_clk = 1'b0;
      if (flip) ctl_dat = ~v[i];
    end
  endtask

  task automatic latch();
    sys(2);
    ctl_lat = 1'b1;
    sys(6);
    ctl_lat = 1'b0;
    sys(12);
  endtask

  task automatic set_defaults();
    e_fmt = '0; e_vl = '1; e_vr = '1;
  endtask

  task automatic t_reset();
    set_defaults();
    chk_all("R1");
  endtask

  task automatic t_format();
    // R6 fields, R9 junk in bits 13:10
    put_bits({2'd0, 4'b1010, 10'b01_11_10_10_01}, 16, 1'b0);
    latch();
    e_fmt = 10'b01_11_10_10_01;
    chk_all("R6");
    chk("R9", "fmt_word", {invert, mute, deemph, rate, wlen, fmt}, 10'h1E9);
  endtask

  task automatic t_volume();
    put_bits({2'd1, 4'b1111, 10'h155}, 16, 1'b0);
    latch();
    e_vl = 10'h155;
    chk_all("R7");
    put_bits({2'd2, 4'b0000, 10'h0AA}, 16, 1'b0);
    latch();
    e_vr = 10'h0AA;
    chk_all("R7");
  endtask

  task automatic t_no_latch();
    put_bits({2'd1, 4'd0, 10'h001}, 16, 1'b0);
    sys(20);
    chk_all("R3");
    latch();
    e_vl = 10'h001;
    chk_all("R3");
  endtask

  task automatic t_edge_sample();
    put_bits({2'd2, 4'd0, 10'h2D4}, 16, 1'b1);
    latch();
    e_vr = 10'h2D4;
    chk_all("R2");
  endtask

  task automatic t_long_word();
    put_bits(32'h1F, 5, 1'b0);
    put_bits({2'd2, 4'd0, 10'h3C3}, 16, 1'b0);
    latch();
    e_vr = 10'h3C3;
    chk_all("R4");
  endtask

  task automatic t_short_word();
    put_bits(32'h3FF, 10, 1'b0);
    latch();
    chk_all("R5");
  endtask

  task automatic t_rsvd();
    put_bits(32'hFFFF, 16, 1'b0);
    latch();
    chk_all("R8");
  endtask

  task automatic t_reset_mid();
    put_bits(32'h55, 8, 1'b0);
    rst_n = 1'b0;
    sys(3);
    set_defaults();
    chk_all("R1");
    rst_n = 1'b1;
    sys(3);
    put_bits(32'h42, 8, 1'b0);
    latch();
    chk_all("R5");
  endtask

  initial begin
    rst_n = 1'b0; ctl_clk = 1'b0; ctl_dat = 1'b0; ctl_lat = 1'b0;
    sys(5);
    t_reset();
    rst_n = 1'b1;
    sys(5);
    t_format();
    t_volume();
    t_no_latch();
    t_edge_sample();
    t_long_word();
    t_short_word();
    t_rsvd();
    t_reset_mid();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule